// File: doc/BRIEF.md
# Transactional L1 Commit and Abort Engine

This block holds the tag and state side of a direct-mapped first-level cache in which every line also carries a transaction mark. A line installed by a transactional fill, or upgraded to modified by a transactional store, is marked. The mark decides where the line goes when a later fill displaces it. A marked line leaves through the victim-store port. An unmarked line leaves through the ordinary next-level port. Each line also keeps a small data word, so that a displaced or committed line carries its contents with it.

When the processor's transaction ends, the block closes it in one of two ways. On a commit request it walks the array one index per cycle. It hands every modified marked line to the victim-store port, flagged as a commit writeback, and invalidates every marked line. Clean marked lines are dropped without a writeback. On an abort request it invalidates every marked line in a single cycle and writes nothing back. In both cases it raises a one-cycle done pulse for the directory. New processor accesses and fills are held off while either operation runs. The coherence request path is reduced to a fill port with a valid/ready handshake, and store upgrades are taken as already granted.

Top module: `txl1_engine`

## Requirements
- R1: After reset every line is invalid, so a load misses. `cpu_ready` and `fill_ready` are high, and `vc_valid`, `nl_valid`, `rsp_valid` and `tx_done` are low.
- R2: A fill with `fill_tx`=1 marks the line. When a later fill displaces it, the line appears on the victim port for that cycle with `vc_addr`={tag,index}, its data, `vc_dirty`=1 if it was modified, and `vc_commit`=0. `nl_valid` stays low.
- R3: A line installed with `fill_tx`=0 and never written transactionally goes to the next-level port when displaced, carrying its address, data and dirty flag. `vc_valid` stays low.
- R4: A transactional store that hits a clean line makes it modified and marks it. A later displacement goes to the victim port with `vc_dirty`=1 and the stored data.
- R5: An accepted access returns `rsp_valid`=1 one cycle later. `rsp_hit` is 1 only when the line is valid and its tag matches. A load hit returns the line's data. A miss changes no line.
- R6: An abort invalidates every marked line in the accepting cycle and sends nothing to either port. Unmarked lines keep hitting. `tx_done` is high in the next cycle only.
- R7: A commit sends each modified marked line to the victim port with `vc_commit`=1 and `vc_dirty`=1, in ascending index order. It sends no clean line. It invalidates all marked lines and leaves unmarked lines valid.
- R8: The commit walk visits one index per cycle. Without back-pressure `tx_done` rises 2^IDX_W cycles after the accepting edge. Each cycle in which a commit writeback waits on `vc_ready`=0 adds one cycle.
- R9: While a commit walk runs, and in a cycle that presents a commit or abort request, `cpu_ready` and `fill_ready` are low.
- R10: A fill whose displaced line's port is not ready is held with `fill_ready`=0, and the resident line is left unchanged.
- R11: A commit and an abort requested in the same cycle are handled as an abort: no writeback, and `tx_done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_ready | output | 1 | Access can be accepted this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_tx | input | 1 | Access belongs to a running transaction |
| cpu_addr | input | TAG_W+IDX_W | Line address, {tag, index} |
| cpu_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response for the access accepted one cycle earlier |
| rsp_hit | output | 1 | Access hit a valid line |
| rsp_rdata | output | DATA_W | Load data, or store data on a store hit |
| fill_valid | input | 1 | Install a line from the directory |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_addr | input | TAG_W+IDX_W | Address of the installed line |
| fill_data | input | DATA_W | Data of the installed line |
| fill_dirty | input | 1 | Install in modified (1) or shared (0) state |
| fill_tx | input | 1 | Installed by a transactional access |
| tx_commit | input | 1 | Commit request pulse |
| tx_abort | input | 1 | Abort request pulse |
| tx_done | output | 1 | Commit or abort finished |
| vc_valid | output | 1 | Line offered to the victim store |
| vc_ready | input | 1 | Victim store accepts |
| vc_addr | output | TAG_W+IDX_W | Victim line address |
| vc_data | output | DATA_W | Victim line data |
| vc_dirty | output | 1 | Victim line is modified |
| vc_commit | output | 1 | 1 = commit writeback, 0 = eviction |
| nl_valid | output | 1 | Line offered to the next level |
| nl_ready | input | 1 | Next level accepts |
| nl_addr | output | TAG_W+IDX_W | Next-level line address |
| nl_data | output | DATA_W | Next-level line data |
| nl_dirty | output | 1 | Next-level line is modified |

## Verification
A lost or stray transaction mark shows only at the next displacement of that line, or at the next commit or abort. The bench therefore follows each mark through to a port. A displacement reveals it on the very cycle the fill is presented. A commit reveals it in the writeback list and its order. A later load reveals it as a hit or a miss one cycle after acceptance. A wrong walk index or a lost stall shows as a wrong cycle count to `tx_done`, or as a missing or repeated writeback. A wrong abort shows as a surviving line one cycle after the done pulse.

// File: rtl/txl1_pkg.sv
`timescale 1ns/1ps
// Shared types for the transactional L1 engine.
// Line state encoding: I = 00, S = 01, M = 11.
package txl1_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_M = 2'b11
    } line_state_e;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_WALK = 1'b1
    } walk_mode_e;
endpackage

// File: rtl/txl1_array.sv
`timescale 1ns/1ps
// Direct-mapped tag/state/mark/data array.
// Each line is held in its own flops so that an abort can clear every
// marked line in one cycle. Two read ports: a lookup port for accesses and
// fills, and a walk port for the commit sequencer.
// Assumes the controller never issues a fill, store or invalidate in the
// cycle it asserts flash_abort.
module txl1_array
    import txl1_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_dirty,
    input  logic              fill_tx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              st_en,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic              st_tx,
    input  logic [DATA_W-1:0] st_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              flash_abort,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_valid,
    output logic              lk_dirty,
    output logic              lk_tx,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  wk_idx,
    output logic [TAG_W-1:0]  wk_tag,
    output logic              wk_valid,
    output logic              wk_dirty,
    output logic              wk_tx,
    output logic [DATA_W-1:0] wk_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0][1:0]        st_flat;
    logic [LINES-1:0]             tx_vec;
    logic [LINES-1:0][TAG_W-1:0]  tag_flat;
    logic [LINES-1:0][DATA_W-1:0] data_flat;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_e       st_r;
        logic              tx_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;

        // Per-line update: abort clear, walk invalidate, fill, store hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r   <= LS_I;
                tx_r   <= 1'b0;
                tag_r  <= '0;
                data_r <= '0;
            end else if (flash_abort) begin
                if (tx_r) begin
                    st_r <= LS_I;
                    tx_r <= 1'b0;
                end
            end else if (inv_en && inv_idx == IDX_W'(g)) begin
                st_r <= LS_I;
                tx_r <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                st_r   <= fill_dirty ? LS_M : LS_S;
                tx_r   <= fill_tx;
                tag_r  <= fill_tag;
                data_r <= fill_data;
            end else if (st_en && st_idx == IDX_W'(g)) begin
                st_r   <= LS_M;
                data_r <= st_data;
                if (st_tx) begin
                    tx_r <= 1'b1;
                end
            end
        end

        assign st_flat[g]   = st_r;
        assign tx_vec[g]    = tx_r;
        assign tag_flat[g]  = tag_r;
        assign data_flat[g] = data_r;
    end

    // Lookup port read.
    always_comb begin
        lk_tag   = tag_flat[lk_idx];
        lk_valid = st_flat[lk_idx] != LS_I;
        lk_dirty = st_flat[lk_idx] == LS_M;
        lk_tx    = tx_vec[lk_idx];
        lk_data  = data_flat[lk_idx];
    end

    // Walk port read.
    always_comb begin
        wk_tag   = tag_flat[wk_idx];
        wk_valid = st_flat[wk_idx] != LS_I;
        wk_dirty = st_flat[wk_idx] == LS_M;
        wk_tx    = tx_vec[wk_idx];
        wk_data  = data_flat[wk_idx];
    end

    AST_ABORT_CLEARS_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        flash_abort |=> (tx_vec == '0)); // R6
endmodule

// File: rtl/txl1_ctrl.sv
`timescale 1ns/1ps
// Commit/abort sequencer.
// Abort: one cycle, flash-clears marked lines. Commit: walks indices
// 0..2^IDX_W-1, one per cycle, requesting a victim writeback for modified
// marked lines and stalling until the victim port is ready. Raises a
// one-cycle done pulse after either operation. Abort wins over commit.
module txl1_ctrl
    import txl1_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_req,
    input  logic             abort_req,
    input  logic             wk_valid,
    input  logic             wk_dirty,
    input  logic             wk_tx,
    input  logic             vc_ready,
    output logic             busy,
    output logic             op_free,
    output logic [IDX_W-1:0] wk_idx,
    output logic             wb_req,
    output logic             wb_inv,
    output logic             flash_abort,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    walk_mode_e       mode_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             mark_line;
    logic             advance;

    // Decode the action for the line under the walk pointer.
    always_comb begin
        mark_line   = wk_valid && wk_tx;
        wb_req      = (mode_q == WK_WALK) && mark_line && wk_dirty;
        wb_inv      = (mode_q == WK_WALK) && mark_line && (!wk_dirty || vc_ready);
        advance     = (mode_q == WK_WALK) && !(wb_req && !vc_ready);
        flash_abort = (mode_q == WK_IDLE) && abort_req;
    end

    // Mode, walk pointer and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WK_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (mode_q)
                WK_IDLE: begin
                    if (abort_req) begin
                        done_q <= 1'b1;
                    end else if (commit_req) begin
                        mode_q <= WK_WALK;
                        idx_q  <= '0;
                    end
                end
                default: begin
                    if (advance) begin
                        if (idx_q == LAST_IDX) begin
                            mode_q <= WK_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign busy    = (mode_q == WK_WALK);
    assign op_free = (mode_q == WK_IDLE) && !commit_req && !abort_req;
    assign wk_idx  = idx_q;
    assign done    = done_q;

    AST_STALL_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !vc_ready) |=> (busy && $stable(wk_idx))); // R8
endmodule

// File: rtl/txl1_route.sv
`timescale 1ns/1ps
// Steers a line leaving the array to the victim-store or next-level port.
// Commit writebacks always use the victim port with the commit flag set.
// Displaced lines go by their transaction mark. Reports whether the chosen
// port can take a displaced line this cycle.
// Assumes a commit writeback and a displacement never coincide.
module txl1_route #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_req,
    input  logic              ev_tx,
    input  logic              ev_dirty,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              wb_req,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              vc_ready,
    input  logic              nl_ready,
    output logic              ev_ok,
    output logic              vc_valid,
    output logic [ADDR_W-1:0] vc_addr,
    output logic [DATA_W-1:0] vc_data,
    output logic              vc_dirty,
    output logic              vc_commit,
    output logic              nl_valid,
    output logic [ADDR_W-1:0] nl_addr,
    output logic [DATA_W-1:0] nl_data,
    output logic              nl_dirty
);
    // Victim port: commit writeback first, else a marked displacement.
    always_comb begin
        vc_valid  = wb_req || (ev_req && ev_tx);
        vc_commit = wb_req;
        vc_addr   = wb_req ? wb_addr : ev_addr;
        vc_data   = wb_req ? wb_data : ev_data;
        vc_dirty  = wb_req ? 1'b1 : ev_dirty;
    end

    // Next-level port: unmarked displacements only.
    always_comb begin
        nl_valid = ev_req && !ev_tx;
        nl_addr  = ev_addr;
        nl_data  = ev_data;
        nl_dirty = ev_dirty;
    end

    // Ready of the port that a displacement would use.
    assign ev_ok = !ev_req || (ev_tx ? vc_ready : nl_ready);

    AST_SINGLE_DESTINATION: assert property (@(posedge clk) disable iff (!rst_n)
        !(vc_valid && nl_valid)); // R3
    AST_NO_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && ev_req)); // R9
endmodule

// File: rtl/txl1_engine.sv
`timescale 1ns/1ps
// Transactional L1 engine top.
// Accepts processor loads/stores (hit/miss reported one cycle later),
// directory fills that may displace the resident line, and transaction
// commit/abort requests. Displaced lines and commit writebacks leave through
// the router. Assumes store upgrades are already granted by the directory.
module txl1_engine
    import txl1_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    output logic                   cpu_ready,
    input  logic                   cpu_write,
    input  logic                   cpu_tx,
    input  logic [TAG_W+IDX_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]      cpu_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [DATA_W-1:0]      rsp_rdata,
    input  logic                   fill_valid,
    output logic                   fill_ready,
    input  logic [TAG_W+IDX_W-1:0] fill_addr,
    input  logic [DATA_W-1:0]      fill_data,
    input  logic                   fill_dirty,
    input  logic                   fill_tx,
    input  logic                   tx_commit,
    input  logic                   tx_abort,
    output logic                   tx_done,
    output logic                   vc_valid,
    input  logic                   vc_ready,
    output logic [TAG_W+IDX_W-1:0] vc_addr,
    output logic [DATA_W-1:0]      vc_data,
    output logic                   vc_dirty,
    output logic                   vc_commit,
    output logic                   nl_valid,
    input  logic                   nl_ready,
    output logic [TAG_W+IDX_W-1:0] nl_addr,
    output logic [DATA_W-1:0]      nl_data,
    output logic                   nl_dirty
);
    localparam int ADDR_W = TAG_W + IDX_W;

    logic [IDX_W-1:0]  cpu_idx, fill_idx, lk_idx, wk_idx;
    logic [TAG_W-1:0]  cpu_tag, fill_tag, lk_tag, wk_tag;
    logic              lk_valid, lk_dirty, lk_tx;
    logic [DATA_W-1:0] lk_data, wk_data;
    logic              wk_valid, wk_dirty, wk_tx;
    logic              busy, op_free, wb_req, wb_inv, flash_abort;
    logic              ev_req, ev_ok, fill_fire, cpu_fire, hit, st_en;

    assign cpu_idx  = cpu_addr[IDX_W-1:0];
    assign cpu_tag  = cpu_addr[IDX_W +: TAG_W];
    assign fill_idx = fill_addr[IDX_W-1:0];
    assign fill_tag = fill_addr[IDX_W +: TAG_W];

    // Request arbitration: fills before accesses, both held off by txn ops.
    always_comb begin
        lk_idx     = fill_valid ? fill_idx : cpu_idx;
        ev_req     = fill_valid && op_free && lk_valid;
        fill_ready = op_free && ev_ok;
        fill_fire  = fill_valid && fill_ready;
        cpu_ready  = op_free && !fill_valid;
        cpu_fire   = cpu_valid && cpu_ready;
        hit        = lk_valid && (lk_tag == cpu_tag);
        st_en      = cpu_fire && cpu_write && hit;
    end

    // Access response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cpu_fire;
            rsp_hit   <= cpu_fire && hit;
            rsp_rdata <= (cpu_fire && hit) ? (cpu_write ? cpu_wdata : lk_data) : '0;
        end
    end

    txl1_array #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_en     (fill_fire),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .fill_dirty  (fill_dirty),
        .fill_tx     (fill_tx),
        .fill_data   (fill_data),
        .st_en       (st_en),
        .st_idx      (cpu_idx),
        .st_tx       (cpu_tx),
        .st_data     (cpu_wdata),
        .inv_en      (wb_inv),
        .inv_idx     (wk_idx),
        .flash_abort (flash_abort),
        .lk_idx      (lk_idx),
        .lk_tag      (lk_tag),
        .lk_valid    (lk_valid),
        .lk_dirty    (lk_dirty),
        .lk_tx       (lk_tx),
        .lk_data     (lk_data),
        .wk_idx      (wk_idx),
        .wk_tag      (wk_tag),
        .wk_valid    (wk_valid),
        .wk_dirty    (wk_dirty),
        .wk_tx       (wk_tx),
        .wk_data     (wk_data)
    );

    txl1_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_req  (tx_commit),
        .abort_req   (tx_abort),
        .wk_valid    (wk_valid),
        .wk_dirty    (wk_dirty),
        .wk_tx       (wk_tx),
        .vc_ready    (vc_ready),
        .busy        (busy),
        .op_free     (op_free),
        .wk_idx      (wk_idx),
        .wb_req      (wb_req),
        .wb_inv      (wb_inv),
        .flash_abort (flash_abort),
        .done        (tx_done)
    );

    txl1_route #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_req    (ev_req),
        .ev_tx     (lk_tx),
        .ev_dirty  (lk_dirty),
        .ev_addr   ({lk_tag, fill_idx}),
        .ev_data   (lk_data),
        .wb_req    (wb_req),
        .wb_addr   ({wk_tag, wk_idx}),
        .wb_data   (wk_data),
        .vc_ready  (vc_ready),
        .nl_ready  (nl_ready),
        .ev_ok     (ev_ok),
        .vc_valid  (vc_valid),
        .vc_addr   (vc_addr),
        .vc_data   (vc_data),
        .vc_dirty  (vc_dirty),
        .vc_commit (vc_commit),
        .nl_valid  (nl_valid),
        .nl_addr   (nl_addr),
        .nl_data   (nl_data),
        .nl_dirty  (nl_dirty)
    );

    AST_WALK_BLOCKS_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cpu_ready && !fill_ready)); // R9
    AST_WALK_END_SIGNALS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tx_done); // R8
    AST_COMMIT_WB_ONLY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_valid && vc_commit) |-> busy); // R7
endmodule

// File: tb/test_txl1_engine.sv
`timescale 1ns/1ps
// Directed bench for txl1_engine (IDX_W=4, TAG_W=8, DATA_W=32).
// Addresses are written as {tag, index}: 12'h605 = tag 0x60, index 5.
module test_txl1_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_write, cpu_tx;
    logic [11:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic        cpu_ready, rsp_valid, rsp_hit;
    logic [31:0] rsp_rdata;
    logic        fill_valid, fill_dirty, fill_tx, fill_ready;
    logic [11:0] fill_addr;
    logic [31:0] fill_data;
    logic        tx_commit, tx_abort, tx_done;
    logic        vc_valid, vc_ready, vc_dirty, vc_commit;
    logic [11:0] vc_addr;
    logic [31:0] vc_data;
    logic        nl_valid, nl_ready, nl_dirty;
    logic [11:0] nl_addr;
    logic [31:0] nl_data;

    int n_cmp = 0;
    int n_bad = 0;

    // Results captured by the helper tasks.
    logic        r_hit;
    logic [31:0] r_data;
    int          e_dest;
    logic [11:0] e_addr;
    logic [31:0] e_data;
    logic        e_dirty, e_commit;
    int          w_cycles, w_count, w_blocked;
    logic [11:0] w_addr [4];
    logic [31:0] w_data [4];

    always #2.5 clk = ~clk;

    txl1_engine i_txl1_engine (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
        .cpu_tx(cpu_tx), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_dirty(fill_dirty), .fill_tx(fill_tx),
        .tx_commit(tx_commit), .tx_abort(tx_abort), .tx_done(tx_done),
        .vc_valid(vc_valid), .vc_ready(vc_ready), .vc_addr(vc_addr),
        .vc_data(vc_data), .vc_dirty(vc_dirty), .vc_commit(vc_commit),
        .nl_valid(nl_valid), .nl_ready(nl_ready), .nl_addr(nl_addr),
        .nl_data(nl_data), .nl_dirty(nl_dirty)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic tx,
                          input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_tx = tx; cpu_addr = a; cpu_wdata = wd;
        @(posedge clk); #1;
        cpu_valid = 1'b0; cpu_write = 1'b0; cpu_tx = 1'b0;
        r_hit  = rsp_valid && rsp_hit;
        r_data = rsp_rdata;
    endtask

    task automatic fill(input logic [11:0] a, input logic [31:0] d,
                        input logic dirty, input logic tx);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_data = d; fill_dirty = dirty; fill_tx = tx;
        #1;
        e_dest = 0; e_addr = '0; e_data = '0; e_dirty = 1'b0; e_commit = 1'b0;
        if (vc_valid) begin
            e_dest = 1; e_addr = vc_addr; e_data = vc_data; e_dirty = vc_dirty; e_commit = vc_commit;
        end else if (nl_valid) begin
            e_dest = 2; e_addr = nl_addr; e_data = nl_data; e_dirty = nl_dirty;
        end
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    // Commit walk; vc_ready held low for the first stall_n offered cycles.
    task automatic run_commit(input int stall_n);
        int seen;
        seen = 0;
        w_cycles = 0; w_count = 0; w_blocked = 0;
        @(negedge clk); tx_commit = 1'b1;
        @(posedge clk); #1; tx_commit = 1'b0;
        while (w_cycles < 100) begin
            @(negedge clk);
            vc_ready = (seen >= stall_n);
            #1;
            if (cpu_ready || fill_ready) w_blocked++;
            if (vc_valid) begin
                seen++;
                if (vc_ready) begin
                    if (w_count < 4) begin
                        w_addr[w_count] = vc_addr;
                        w_data[w_count] = vc_data;
                    end
                    w_count++;
                    check("R7", "writeback commit flag", vc_commit, 1'b1);
                    check("R7", "writeback dirty flag", vc_dirty, 1'b1);
                end
            end
            @(posedge clk); w_cycles++; #1;
            if (tx_done) break;
        end
        vc_ready = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check("R1", "cpu_ready", cpu_ready, 1'b1);
        check("R1", "fill_ready", fill_ready, 1'b1);
        check("R1", "vc_valid", vc_valid, 1'b0);
        check("R1", "nl_valid", nl_valid, 1'b0);
        check("R1", "rsp_valid", rsp_valid, 1'b0);
        check("R1", "tx_done", tx_done, 1'b0);
        access(1'b0, 1'b0, 12'h005, 32'h0);
        check("R1", "load after reset hit", r_hit, 1'b0);
    endtask

    task automatic t_lookup;
        fill(12'h121, 32'hA0A0_0001, 1'b0, 1'b0);
        check("R5", "no displacement into empty line", e_dest, 0);
        access(1'b0, 1'b0, 12'h121, 32'h0);
        check("R5", "load hit", r_hit, 1'b1);
        check("R5", "load data", r_data, 32'hA0A0_0001);
        access(1'b0, 1'b0, 12'h131, 32'h0);
        check("R5", "other tag misses", r_hit, 1'b0);
        access(1'b1, 1'b0, 12'h131, 32'h5);
        check("R5", "store miss", r_hit, 1'b0);
        access(1'b0, 1'b0, 12'h121, 32'h0);
        check("R5", "miss left line intact", r_hit, 1'b1);
        check("R5", "miss left data intact", r_data, 32'hA0A0_0001);
    endtask

    task automatic t_route_plain;
        fill(12'h131, 32'hB0B0_0002, 1'b0, 1'b0);
        check("R3", "unmarked line to next level", e_dest, 2);
        check("R3", "next-level address", e_addr, 12'h121);
        check("R3", "next-level data", e_data, 32'hA0A0_0001);
        check("R3", "next-level dirty", e_dirty, 1'b0);
    endtask

    task automatic t_route_marked;
        fill(12'h302, 32'hC0C0_0003, 1'b1, 1'b1);
        fill(12'h312, 32'hC0C0_0004, 1'b0, 1'b0);
        check("R2", "marked line to victim port", e_dest, 1);
        check("R2", "victim address", e_addr, 12'h302);
        check("R2", "victim data", e_data, 32'hC0C0_0003);
        check("R2", "victim dirty", e_dirty, 1'b1);
        check("R2", "eviction not a commit", e_commit, 1'b0);
    endtask

    task automatic t_upgrade;
        fill(12'h403, 32'hD0D0_0005, 1'b0, 1'b0);
        access(1'b1, 1'b1, 12'h403, 32'hD0D0_0006);
        check("R4", "tx store hit", r_hit, 1'b1);
        fill(12'h413, 32'hD0D0_0007, 1'b0, 1'b0);
        check("R4", "upgraded line to victim port", e_dest, 1);
        check("R4", "upgraded line dirty", e_dirty, 1'b1);
        check("R4", "upgraded line data", e_data, 32'hD0D0_0006);
    endtask

    task automatic t_backpressure;
        fill(12'h504, 32'hE0E0_0008, 1'b0, 1'b0);
        @(negedge clk);
        nl_ready = 1'b0;
        fill_valid = 1'b1; fill_addr = 12'h514; fill_data = 32'hE0E0_0009;
        fill_dirty = 1'b0; fill_tx = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R10", "fill held", fill_ready, 1'b0);
            check("R10", "displacement offered", nl_valid, 1'b1);
            @(negedge clk);
        end
        fill_valid = 1'b0; nl_ready = 1'b1;
        access(1'b0, 1'b0, 12'h504, 32'h0);
        check("R10", "resident line kept", r_hit, 1'b1);
        check("R10", "resident data kept", r_data, 32'hE0E0_0008);
    endtask

    task automatic t_abort;
        fill(12'h805, 32'h1111_0005, 1'b1, 1'b1);
        fill(12'h816, 32'h1111_0006, 1'b0, 1'b1);
        fill(12'h827, 32'h1111_0007, 1'b1, 1'b0);
        @(negedge clk); tx_abort = 1'b1; #1;
        check("R9", "access blocked during abort", cpu_ready, 1'b0);
        check("R9", "fill blocked during abort", fill_ready, 1'b0);
        check("R6", "no victim traffic", vc_valid, 1'b0);
        check("R6", "no next-level traffic", nl_valid, 1'b0);
        @(posedge clk); #1; tx_abort = 1'b0;
        check("R6", "done after abort", tx_done, 1'b1);
        @(posedge clk); #1;
        check("R6", "done is one cycle", tx_done, 1'b0);
        access(1'b0, 1'b0, 12'h805, 32'h0);
        check("R6", "marked dirty line gone", r_hit, 1'b0);
        access(1'b0, 1'b0, 12'h816, 32'h0);
        check("R6", "marked clean line gone", r_hit, 1'b0);
        access(1'b0, 1'b0, 12'h827, 32'h0);
        check("R6", "unmarked line kept", r_hit, 1'b1);
    endtask

    task automatic t_commit;
        fill(12'h608, 32'h2222_0008, 1'b1, 1'b1);
        fill(12'h609, 32'h2222_0009, 1'b0, 1'b1);
        fill(12'h60A, 32'h2222_000A, 1'b1, 1'b0);
        fill(12'h61B, 32'h2222_000B, 1'b1, 1'b1);
        run_commit(0);
        check("R8", "walk length", w_cycles, 16);
        check("R9", "cycles with requests open", w_blocked, 0);
        check("R7", "writeback count", w_count, 2);
        check("R7", "first writeback address", w_addr[0], 12'h608);
        check("R7", "first writeback data", w_data[0], 32'h2222_0008);
        check("R7", "second writeback address", w_addr[1], 12'h61B);
        check("R7", "second writeback data", w_data[1], 32'h2222_000B);
        @(posedge clk); #1;
        check("R9", "done is one cycle", tx_done, 1'b0);
        access(1'b0, 1'b0, 12'h608, 32'h0);
        check("R7", "committed dirty line invalid", r_hit, 1'b0);
        access(1'b0, 1'b0, 12'h609, 32'h0);
        check("R7", "committed clean line invalid", r_hit, 1'b0);
        access(1'b0, 1'b0, 12'h60A, 32'h0);
        check("R7", "unmarked line kept", r_hit, 1'b1);
    endtask

    task automatic t_commit_stall;
        fill(12'h70C, 32'h3333_000C, 1'b1, 1'b1);
        run_commit(3);
        check("R8", "walk length with three stalls", w_cycles, 19);
        check("R8", "single transfer", w_count, 1);
        check("R8", "stalled writeback address", w_addr[0], 12'h70C);
        access(1'b0, 1'b0, 12'h70C, 32'h0);
        check("R7", "stalled line invalid after commit", r_hit, 1'b0);
    endtask

    task automatic t_both;
        fill(12'h70D, 32'h4444_000D, 1'b1, 1'b1);
        @(negedge clk); tx_commit = 1'b1; tx_abort = 1'b1; #1;
        check("R11", "no writeback on joint request", vc_valid, 1'b0);
        @(posedge clk); #1; tx_commit = 1'b0; tx_abort = 1'b0;
        check("R11", "done after one cycle", tx_done, 1'b1);
        @(negedge clk); #1;
        check("R11", "no walk started", cpu_ready, 1'b1);
        check("R11", "no victim traffic", vc_valid, 1'b0);
        access(1'b0, 1'b0, 12'h70D, 32'h0);
        check("R11", "marked line dropped", r_hit, 1'b0);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog R1..all: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cpu_valid = 1'b0; cpu_write = 1'b0; cpu_tx = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        fill_valid = 1'b0; fill_addr = '0; fill_data = '0; fill_dirty = 1'b0; fill_tx = 1'b0;
        tx_commit = 1'b0; tx_abort = 1'b0;
        vc_ready = 1'b1; nl_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_lookup();
        t_route_plain();
        t_route_marked();
        t_upgrade();
        t_backpressure();
        t_abort();
        t_commit();
        t_commit_stall();
        t_both();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule